// File: doc/BRIEF.md
# Bi-endian Aligned Memory Access Port

The block connects a processor core to a byte-organised RAM of 2^N bytes, which the block holds inside itself. Each request moves a byte, a 16-bit half or a 32-bit word. A select bit that comes with the request sets the byte order for that access, little-endian or big-endian. The block therefore serves cores that change byte order at run time, or masters that expect different orders.

Addresses are reduced to the array size, so accesses wrap around the array. They are also pulled down to the natural boundary of the access size, and no misalignment is reported. Byte and half reads return either zero-extended or sign-extended 32-bit values. Read and write share one datapath for byte lanes, so data written with one byte order reads back unchanged with the same order. A read returns its data on the clock after the request.

Top module: `endian_mem_port`

## Requirements
- R1: After reset, and on every cycle that carries no read response, `rsp_valid` is 0 and `rsp_rdata` is 0.
- R2: Address bits at or above N are ignored. With the default N=8, address 0x110 reaches the same bytes as 0x10.
- R3: A half access ignores address bit 0. A word access ignores address bits 1:0. This applies to both reads and writes.
- R4: In little-endian mode (`req_big`=0), a word read at aligned address A returns mem[A+3] in bits 31:24, mem[A+2] in 23:16, mem[A+1] in 15:8 and mem[A] in 7:0.
- R5: In big-endian mode (`req_big`=1), a word read at A returns mem[A] in bits 31:24, mem[A+1] in 23:16, mem[A+2] in 15:8 and mem[A+3] in 7:0.
- R6: A half read at A returns mem[A+1] in bits 15:8 and mem[A] in 7:0 in little-endian mode. In big-endian mode it returns mem[A] in 15:8 and mem[A+1] in 7:0.
- R7: A byte access uses only mem[A] and gives the same result in both byte orders.
- R8: A byte read (`req_size`=0) with `req_signed`=1 copies bit 7 into bits 31:8. With `req_signed`=0, bits 31:8 are zero.
- R9: A half read (`req_size`=1) with `req_signed`=1 copies bit 15 into bits 31:16. With `req_signed`=0, bits 31:16 are zero.
- R10: A write places its bytes in the same lane order that a read of the same size and byte order uses. A read back with the same size and order returns the written value.
- R11: A read request (`req_valid`=1, `req_write`=0) raises `rsp_valid` for exactly the following cycle. A write request raises no response.
- R12: A byte write changes one byte and a half write changes two bytes. The other bytes of the enclosing word keep their values. Size encoding: 0 byte, 1 half, 2 or 3 word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half, 2/3 word |
| req_signed | input | 1 | Sign-extend byte/half read data |
| req_big | input | 1 | 1 = big-endian lane order for this request |
| req_addr | input | ADDR_W | Byte address (wrapped and aligned inside) |
| req_wdata | input | 32 | Write value, right-justified |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, extended to 32 bits |

## Verification
A read's data and `rsp_valid` appear at the first rising edge after the request is taken. A write's bytes become visible to a read issued on any later cycle. The bench drives each request on a falling edge and samples the response at the next falling edge. Every read check therefore looks exactly one edge after its request, and a late or early response shows up as a wrong value. The timing scenario also samples the cycle after a read response and the cycle after a write, to confirm that `rsp_valid` is low and the data is zero.

// File: rtl/mem_port_pkg.sv
package mem_port_pkg;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    // byte count of one access of the given size code
    function automatic int size_bytes(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            default: return 4;
        endcase
    endfunction

    typedef struct packed {
        logic       vld;
        logic [1:0] size;
        logic       sgn;
        logic       big;
    } rsp_ctx_t;

endpackage

// File: rtl/addr_align.sv
module addr_align #(
    parameter int ADDR_W = 32,
    parameter int N      = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic [N-1:0]      aligned
);
    import mem_port_pkg::*;

    localparam logic [N-1:0] LOW_KEEP_HALF = ~{{(N-1){1'b0}}, 1'b1};
    localparam logic [N-1:0] LOW_KEEP_WORD = ~{{(N-2){1'b0}}, 2'b11};

    logic [N-1:0] wrapped;

    always_comb begin
        wrapped = addr[N-1:0];
        case (size)
            SZ_BYTE: aligned = wrapped;
            SZ_HALF: aligned = wrapped & LOW_KEEP_HALF;
            default: aligned = wrapped & LOW_KEEP_WORD;
        endcase
    end
endmodule

// File: rtl/byte_ram.sv
module byte_ram #(
    parameter int N = 8
) (
    input  logic                clk,
    input  logic                rd_en,
    input  logic [3:0]          wr_en,
    input  logic [N-1:0]        base,
    input  logic [3:0][7:0]     wr_bytes,
    output logic [3:0][7:0]     rd_bytes
);
    localparam int DEPTH = 1 << N;

    logic [7:0] mem [DEPTH];
    logic [3:0][N-1:0] idx;

    always_comb begin
        for (int i = 0; i < 4; i++) begin
            idx[i] = base + N'(i);
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < 4; i++) begin
            if (wr_en[i]) begin
                mem[idx[i]] <= wr_bytes[i];
            end
            if (rd_en) begin
                rd_bytes[i] <= mem[idx[i]];
            end
        end
    end
endmodule

// File: rtl/lane_pack.sv
module lane_pack (
    input  logic [1:0]      size,
    input  logic            big,
    input  logic            wr,
    input  logic [31:0]     wdata,
    output logic [3:0]      lane_en,
    output logic [3:0][7:0] lane_data
);
    import mem_port_pkg::*;

    int          nb;
    logic [31:0] shifted;

    always_comb begin
        nb        = size_bytes(size);
        lane_en   = '0;
        lane_data = '0;
        shifted   = '0;
        for (int k = 0; k < 4; k++) begin
            if (k < nb) begin
                lane_en[k] = wr;
                if (big) begin
                    shifted = wdata >> (8 * (nb - 1 - k));
                end else begin
                    shifted = wdata >> (8 * k);
                end
                lane_data[k] = shifted[7:0];
            end
        end
    end
endmodule

// File: rtl/lane_unpack.sv
module lane_unpack (
    input  logic            vld,
    input  logic [1:0]      size,
    input  logic            big,
    input  logic            sgn,
    input  logic [3:0][7:0] lane_data,
    output logic [31:0]     rdata
);
    import mem_port_pkg::*;

    int          nb;
    logic [31:0] raw;

    always_comb begin
        nb  = size_bytes(size);
        raw = '0;
        for (int j = 0; j < 4; j++) begin
            if (j < nb) begin
                if (big) begin
                    raw = raw | (32'(lane_data[nb - 1 - j]) << (8 * j));
                end else begin
                    raw = raw | (32'(lane_data[j]) << (8 * j));
                end
            end
        end
        case (size)
            SZ_BYTE: rdata = {{24{sgn & raw[7]}}, raw[7:0]};
            SZ_HALF: rdata = {{16{sgn & raw[15]}}, raw[15:0]};
            default: rdata = raw;
        endcase
        if (!vld) begin
            rdata = '0;
        end
    end
endmodule

// File: rtl/endian_mem_port.sv
module endian_mem_port #(
    parameter int ADDR_W = 32,
    parameter int N      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic              req_signed,
    input  logic              req_big,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata
);
    import mem_port_pkg::*;

    rsp_ctx_t        ctx_d, ctx_q;
    logic [N-1:0]    base;
    logic [3:0]      lane_en;
    logic [3:0][7:0] lane_wr;
    logic [3:0][7:0] lane_rd;
    logic            rd_go;

    addr_align #(.ADDR_W(ADDR_W), .N(N)) u_align (
        .addr    (req_addr),
        .size    (req_size),
        .aligned (base)
    );

    lane_pack u_pack (
        .size      (req_size),
        .big       (req_big),
        .wr        (req_valid & req_write),
        .wdata     (req_wdata),
        .lane_en   (lane_en),
        .lane_data (lane_wr)
    );

    byte_ram #(.N(N)) u_ram (
        .clk      (clk),
        .rd_en    (rd_go),
        .wr_en    (lane_en),
        .base     (base),
        .wr_bytes (lane_wr),
        .rd_bytes (lane_rd)
    );

    lane_unpack u_unpack (
        .vld       (ctx_q.vld),
        .size      (ctx_q.size),
        .big       (ctx_q.big),
        .sgn       (ctx_q.sgn),
        .lane_data (lane_rd),
        .rdata     (rsp_rdata)
    );

    always_comb begin
        rd_go      = req_valid & ~req_write;
        ctx_d      = ctx_q;
        ctx_d.vld  = rd_go;
        if (rd_go) begin
            ctx_d.size = req_size;
            ctx_d.sgn  = req_signed;
            ctx_d.big  = req_big;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign rsp_valid = ctx_q.vld;
endmodule

// File: rtl/mem_port_chk.sv
module mem_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [1:0]  req_size,
    input logic        req_signed,
    input logic        rsp_valid,
    input logic [31:0] rsp_rdata
);
    // R11
    read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    // R11
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_rdata == 32'd0));

    // R8
    byte_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_size) == 2'd0) |->
            (rsp_rdata[31:8] == ($past(req_signed) ? {24{rsp_rdata[7]}} : 24'd0)));

    // R9
    half_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_size) == 2'd1) |->
            (rsp_rdata[31:16] == ($past(req_signed) ? {16{rsp_rdata[15]}} : 16'd0)));
endmodule

bind endian_mem_port mem_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_size   (req_size),
    .req_signed (req_signed),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
);

// File: tb/sim_endian_mem_port.sv
module sim_endian_mem_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic        req_signed = 1'b0;
    logic        req_big = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    endian_mem_port u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_signed(req_signed), .req_big(req_big),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [1:0] sz, input logic bg,
                      input logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_size = sz; req_big = bg;
        req_signed = 0; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd(input logic [31:0] a, input logic [1:0] sz, input logic sg,
                      input logic bg, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_size = sz; req_big = bg;
        req_signed = sg; req_addr = a;
        @(negedge clk);
        d = rsp_rdata;
        chk("R11 valid", {31'd0, rsp_valid}, 32'd1);
        req_valid = 0;
    endtask

    task automatic t_reset();
        chk("R1 reset valid", {31'd0, rsp_valid}, 32'd0);
        chk("R1 reset data", rsp_rdata, 32'd0);
    endtask

    task automatic t_order();
        logic [31:0] d;
        wr(32'h10, 2'd2, 1'b0, 32'h11223344);
        rd(32'h10, 2'd2, 1'b0, 1'b0, d); chk("R10 LE roundtrip", d, 32'h11223344);
        rd(32'h10, 2'd0, 1'b0, 1'b0, d); chk("R4 LE byte0", d, 32'h44);
        rd(32'h13, 2'd0, 1'b0, 1'b1, d); chk("R7 byte BE", d, 32'h11);
        rd(32'h10, 2'd2, 1'b0, 1'b1, d); chk("R5 BE word", d, 32'h44332211);
        wr(32'h20, 2'd2, 1'b1, 32'hA1B2C3D4);
        rd(32'h20, 2'd0, 1'b0, 1'b0, d); chk("R5 BE byte0", d, 32'hA1);
        rd(32'h20, 2'd2, 1'b0, 1'b1, d); chk("R10 BE roundtrip", d, 32'hA1B2C3D4);
        rd(32'h20, 2'd1, 1'b0, 1'b0, d); chk("R6 LE half", d, 32'hB2A1);
        rd(32'h22, 2'd1, 1'b0, 1'b1, d); chk("R6 BE half", d, 32'hC3D4);
    endtask

    task automatic t_ext();
        logic [31:0] d;
        wr(32'h30, 2'd0, 1'b0, 32'hFFFFFF85);
        rd(32'h30, 2'd0, 1'b1, 1'b0, d); chk("R8 signed byte", d, 32'hFFFFFF85);
        rd(32'h30, 2'd0, 1'b0, 1'b0, d); chk("R8 unsigned byte", d, 32'h85);
        wr(32'h31, 2'd0, 1'b1, 32'h7F);
        rd(32'h31, 2'd0, 1'b1, 1'b1, d); chk("R8 positive byte", d, 32'h7F);
        wr(32'h32, 2'd1, 1'b1, 32'h8001);
        rd(32'h32, 2'd1, 1'b1, 1'b1, d); chk("R9 signed half", d, 32'hFFFF8001);
        rd(32'h32, 2'd1, 1'b0, 1'b1, d); chk("R9 unsigned half", d, 32'h8001);
        rd(32'h32, 2'd1, 1'b1, 1'b0, d); chk("R9 LE signed half", d, 32'h0180);
    endtask

    task automatic t_align();
        logic [31:0] d;
        rd(32'h13, 2'd2, 1'b0, 1'b0, d); chk("R3 word misaligned read", d, 32'h11223344);
        rd(32'h11, 2'd1, 1'b0, 1'b0, d); chk("R3 half misaligned read", d, 32'h3344);
        wr(32'h27, 2'd2, 1'b0, 32'hCAFEF00D);
        rd(32'h24, 2'd2, 1'b0, 1'b0, d); chk("R3 word misaligned write", d, 32'hCAFEF00D);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        rd(32'h110, 2'd2, 1'b0, 1'b0, d); chk("R2 wrap read", d, 32'h11223344);
        wr(32'hFFFFFF40, 2'd0, 1'b0, 32'h5A);
        rd(32'h40, 2'd0, 1'b0, 1'b0, d); chk("R2 wrap write", d, 32'h5A);
    endtask

    task automatic t_partial();
        logic [31:0] d;
        wr(32'h11, 2'd0, 1'b0, 32'hEE);
        rd(32'h10, 2'd2, 1'b0, 1'b0, d); chk("R12 byte write", d, 32'h1122EE44);
        wr(32'h12, 2'd1, 1'b0, 32'hBEEF);
        rd(32'h10, 2'd2, 1'b0, 1'b0, d); chk("R12 half write", d, 32'hBEEFEE44);
    endtask

    task automatic t_timing();
        logic [31:0] d;
        rd(32'h10, 2'd2, 1'b0, 1'b0, d);
        @(negedge clk);
        chk("R11 one-cycle pulse", {31'd0, rsp_valid}, 32'd0);
        chk("R1 idle data", rsp_rdata, 32'd0);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_size = 2'd2; req_addr = 32'h50; req_wdata = 32'h1;
        @(negedge clk);
        req_valid = 0; req_write = 0;
        chk("R11 write no response", {31'd0, rsp_valid}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_ext();
        t_align();
        t_wrap();
        t_partial();
        t_timing();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule